// File: doc/BRIEF.md
# Byte/Word Register ALU with Selectable Flag Update

This block is the arithmetic and logic stage of a small microcoded engine built around sixteen 8-bit registers. It takes one 16-bit microinstruction and the read data of the operand registers. It returns a result, per-byte write enables, the destination register index and a new condition flag vector. The outputs are registered, so everything appears one clock after the inputs were presented.

Bits 7..4 of the instruction name a source register B and bits 3..0 a destination register A. The register file outside the block reads A, A+1, B and B+1 and presents them as `a_lo`, `a_hi`, `b_lo` and `b_hi`. Bit 9 selects a 16-bit word operation on the even/odd pair, where A must be even and A+1 holds the high byte. Bit 8 decides whether the flag vector is written. Two-operand operations compute A op B. Single-operand operations (increment, decrement, negate, complement, shifts) take their operand from B. In both cases the result goes to A.

Top module: `byte_word_alu`

## Requirements
- R1: Each output reflects the inputs present at the previous rising clock edge. `wb_idx` equals instruction bits 3..0. While `rst_n` is low, every output is zero.
- R2: When bit 9 is 0 (byte), a writing operation raises `we_lo` only and drives `result[15:8]` to zero. When bit 9 is 1 (word), it raises both enables, and the operands are {a_hi,a_lo} and {b_hi,b_lo}.
- R3: When bit 8 is 0, `flags_out` equals `flags_in`.
- R4: Bits 15..10 select the arithmetic operation: 101000 adds A+B, 101010 adds A+B+C, 101100 computes A−B, and 101110 computes A−B−C. For the two subtractions, C reports a borrow.
- R5: Group 101101 (compare, A−B) and group 110001 (test, A AND B) produce flags exactly like subtract and AND. Neither raises a write enable.
- R6: Groups 110000 AND, 110010 OR, 110011 XOR and 110100 A AND NOT B clear the C, V, C8 and C4 flags.
- R7: Groups 100100 (B+1), 100101 (B+2), 101111 (B−1, C as borrow), 100110 (0−B, C as borrow) and 100111 (NOT B, which clears C, V, C8 and C4) all use B as their source.
- R8: Groups 100010 and 100011 shift B left. Groups 110110 and 110111 shift B right. The lowest group bit 0 selects C as the fill bit, and 1 selects zero fill. C receives the bit shifted out, and V, C8 and C4 are cleared.
- R9: Flag vector bits are: 0 C, 1 V (signed overflow), 2 Z (whole result zero), 3 N (result MSB), 4 C8 (carry/borrow out of bit 7), 5 C4 (carry/borrow out of bit 3), 6 ZB (low byte zero), 7 NB (bit 7 of result).
- R10: Every other opcode group performs no write and leaves the flags unchanged, even when bit 8 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Microinstruction |
| a_lo | input | 8 | Register A read data |
| a_hi | input | 8 | Register A+1 read data |
| b_lo | input | 8 | Register B read data |
| b_hi | input | 8 | Register B+1 read data |
| flags_in | input | 8 | Current flag vector |
| result | output | 16 | Value to write to A (low) and A+1 (high) |
| we_lo | output | 1 | Write enable for register A |
| we_hi | output | 1 | Write enable for register A+1 |
| wb_idx | output | 4 | Destination register index |
| flags_out | output | 8 | Next flag vector |

## Verification
The hardest corners to reach are the signed-overflow and borrow boundaries, where V, C, C8 and C4 change together. Examples are the most negative word being negated or decremented, and a subtract with an incoming borrow whose low nibbles are equal. Uniform random operands almost never land on those corners. The stimulus therefore draws each operand byte from a weighted set of 00, FF, 80 and 7F mixed with random values. It sweeps all 256 opcode high bytes, so every group is covered in both widths and both flag modes. An integer reference model computes the expected values.

// File: rtl/byte_word_alu.sv
module byte_word_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] instr,
  input  logic [7:0]  a_lo,
  input  logic [7:0]  a_hi,
  input  logic [7:0]  b_lo,
  input  logic [7:0]  b_hi,
  input  logic [7:0]  flags_in,
  output logic [15:0] result,
  output logic        we_lo,
  output logic        we_hi,
  output logic [3:0]  wb_idx,
  output logic [7:0]  flags_out
);
  typedef enum logic [4:0] {
    OP_NONE, OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_DEC, OP_INC1, OP_INC2, OP_NEG,
    OP_NOT, OP_AND, OP_TST, OP_OR, OP_XOR, OP_ANDN, OP_SHLC, OP_SHL0, OP_SHRC, OP_SHR0
  } op_e;

  op_e op;
  always_comb begin
    case (instr[15:10])
      6'b100010: op = OP_SHLC;
      6'b100011: op = OP_SHL0;
      6'b100100: op = OP_INC1;
      6'b100101: op = OP_INC2;
      6'b100110: op = OP_NEG;
      6'b100111: op = OP_NOT;
      6'b101000: op = OP_ADD;
      6'b101010: op = OP_ADC;
      6'b101100: op = OP_SUB;
      6'b101101: op = OP_CMP;
      6'b101110: op = OP_SBC;
      6'b101111: op = OP_DEC;
      6'b110000: op = OP_AND;
      6'b110001: op = OP_TST;
      6'b110010: op = OP_OR;
      6'b110011: op = OP_XOR;
      6'b110100: op = OP_ANDN;
      6'b110110: op = OP_SHRC;
      6'b110111: op = OP_SHR0;
      default:   op = OP_NONE;
    endcase
  end

  logic        wide;
  logic [15:0] ax, bx;
  assign wide = instr[9];
  assign ax   = wide ? {a_hi, a_lo} : {8'h00, a_lo};
  assign bx   = wide ? {b_hi, b_lo} : {8'h00, b_lo};

  logic [15:0] x, y;
  logic        ci, borrow;
  always_comb begin
    x = ax; y = bx; ci = 1'b0; borrow = 1'b0;
    case (op)
      OP_ADC:         ci = flags_in[0];
      OP_SUB, OP_CMP: begin y = ~bx; ci = 1'b1; borrow = 1'b1; end
      OP_SBC:         begin y = ~bx; ci = ~flags_in[0]; borrow = 1'b1; end
      OP_INC1:        begin x = bx; y = 16'd1; end
      OP_INC2:        begin x = bx; y = 16'd2; end
      OP_DEC:         begin x = bx; y = 16'hFFFE; ci = 1'b1; borrow = 1'b1; end
      OP_NEG:         begin x = 16'd0; y = ~bx; ci = 1'b1; borrow = 1'b1; end
      default: ;
    endcase
  end

  logic [4:0]  s4;
  logic [8:0]  s8;
  logic [16:0] s16;
  assign s4  = {1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'b0, ci};
  assign s8  = {1'b0, x[7:0]} + {1'b0, y[7:0]} + {8'b0, ci};
  assign s16 = {1'b0, x} + {1'b0, y} + {16'b0, ci};

  logic is_arith, is_shift, writes, upd, fill;
  assign is_arith = op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_DEC, OP_INC1, OP_INC2, OP_NEG};
  assign is_shift = op inside {OP_SHLC, OP_SHL0, OP_SHRC, OP_SHR0};
  assign writes   = (op != OP_NONE) && (op != OP_CMP) && (op != OP_TST);
  assign upd      = instr[8] && (op != OP_NONE);
  assign fill     = (op == OP_SHLC || op == OP_SHRC) && flags_in[0];

  logic [15:0] r;
  logic        cout;
  always_comb begin
    cout = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_DEC, OP_INC1, OP_INC2, OP_NEG: begin
        r = s16[15:0]; cout = wide ? s16[16] : s8[8];
      end
      OP_AND, OP_TST: r = ax & bx;
      OP_OR:          r = ax | bx;
      OP_XOR:         r = ax ^ bx;
      OP_ANDN:        r = ax & ~bx;
      OP_NOT:         r = ~bx;
      OP_SHLC, OP_SHL0: begin
        r = {bx[14:0], fill}; cout = wide ? bx[15] : bx[7];
      end
      OP_SHRC, OP_SHR0: begin
        r = wide ? {fill, bx[15:1]} : {8'h00, fill, bx[7:1]}; cout = bx[0];
      end
      default: r = 16'h0000;
    endcase
  end

  logic [15:0] rm;
  logic        msb, xm, ym, v, c, c8f, c4f;
  logic [7:0]  newf;
  assign rm   = wide ? r : {8'h00, r[7:0]};
  assign msb  = wide ? rm[15] : rm[7];
  assign xm   = wide ? x[15] : x[7];
  assign ym   = wide ? y[15] : y[7];
  assign v    = is_arith && (xm == ym) && (msb != xm);
  assign c    = is_arith ? (cout ^ borrow) : (is_shift && cout);
  assign c8f  = is_arith && (s8[8] ^ borrow);
  assign c4f  = is_arith && (s4[4] ^ borrow);
  assign newf = {rm[7], rm[7:0] == 8'h00, c4f, c8f, msb, rm == 16'h0000, v, c};

  logic ran;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0; we_lo <= 1'b0; we_hi <= 1'b0; wb_idx <= '0; flags_out <= '0; ran <= 1'b0;
    end else begin
      result    <= rm;
      we_lo     <= writes;
      we_hi     <= writes && wide;
      wb_idx    <= instr[3:0];
      flags_out <= upd ? newf : flags_in;
      ran       <= 1'b1;
    end
  end

  a_r2_hi_needs_lo: assert property (@(posedge clk) disable iff (!rst_n)
    we_hi |-> we_lo);
  a_r2_byte_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo && !we_hi) |-> (result[15:8] == 8'h00));
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ran && !$past(instr[8])) |-> (flags_out == $past(flags_in)));
  a_r5_no_write_cmp_tst: assert property (@(posedge clk) disable iff (!rst_n)
    (ran && ($past(instr[15:10]) == 6'b101101 || $past(instr[15:10]) == 6'b110001)) |-> (!we_lo && !we_hi));
  a_r9_byte_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ran && we_lo && $past(instr[8])) |-> (flags_out[7] == result[7] && flags_out[6] == (result[7:0] == 8'h00)));
  a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ran && we_lo && $past(instr[8])) |-> (flags_out[2] == (result == 16'h0000)));
  a_r10_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ran && ($past(instr[15:10]) == 6'b110101 || $past(instr[15:12]) == 4'b0111)) |-> (!we_lo && flags_out == $past(flags_in)));
endmodule

// File: tb/tb_byte_word_alu.sv
module tb_byte_word_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0, flags_in = '0;
  logic [15:0] result;
  logic        we_lo, we_hi;
  logic [3:0]  wb_idx;
  logic [7:0]  flags_out;

  byte_word_alu dut (.clk(clk), .rst_n(rst_n), .instr(instr), .a_lo(a_lo), .a_hi(a_hi),
    .b_lo(b_lo), .b_hi(b_hi), .flags_in(flags_in), .result(result), .we_lo(we_lo),
    .we_hi(we_hi), .wb_idx(wb_idx), .flags_out(flags_out));

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  int W, m, er;
  bit eC, eV, eC8, eC4, ew, def;
  string tg;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h instr=%h", tag, act, exp, instr);
    end
  endtask

  function automatic int sgn(int val, int w);
    return (val >= (1 << (w - 1))) ? val - (1 << w) : val;
  endfunction

  function automatic bit ovf(int s, int w);
    return (s > (1 << (w - 1)) - 1) || (s < -(1 << (w - 1)));
  endfunction

  task do_add(int xv, int yv, int cv);
    int full;
    full = xv + yv + cv;
    er  = full & m;
    eC  = ((full >> W) & 1) != 0;
    eC8 = ((((xv & 255) + (yv & 255) + cv) >> 8) & 1) != 0;
    eC4 = ((((xv & 15) + (yv & 15) + cv) >> 4) & 1) != 0;
    eV  = ovf(sgn(xv, W) + sgn(yv, W) + cv, W);
  endtask

  task do_sub(int xv, int yv, int bv);
    er  = (xv - yv - bv) & m;
    eC  = xv < yv + bv;
    eC8 = (xv & 255) < (yv & 255) + bv;
    eC4 = (xv & 15) < (yv & 15) + bv;
    eV  = ovf(sgn(xv, W) - sgn(yv, W) - bv, W);
  endtask

  task model(output logic [7:0] ef);
    int a, b, cin;
    W = instr[9] ? 16 : 8;
    m = (1 << W) - 1;
    a = instr[9] ? int'({a_hi, a_lo}) : int'(a_lo);
    b = instr[9] ? int'({b_hi, b_lo}) : int'(b_lo);
    cin = int'(flags_in[0]);
    eC = 0; eV = 0; eC8 = 0; eC4 = 0; ew = 1; def = 1; er = 0;
    case (instr[15:10])
      6'b101000: begin tg = "R4"; do_add(a, b, 0); end
      6'b101010: begin tg = "R4"; do_add(a, b, cin); end
      6'b101100: begin tg = "R4"; do_sub(a, b, 0); end
      6'b101110: begin tg = "R4"; do_sub(a, b, cin); end
      6'b101101: begin tg = "R5"; do_sub(a, b, 0); ew = 0; end
      6'b110001: begin tg = "R5"; er = a & b; ew = 0; end
      6'b110000: begin tg = "R6"; er = a & b; end
      6'b110010: begin tg = "R6"; er = a | b; end
      6'b110011: begin tg = "R6"; er = a ^ b; end
      6'b110100: begin tg = "R6"; er = a & ~b & m; end
      6'b100100: begin tg = "R7"; do_add(b, 1, 0); end
      6'b100101: begin tg = "R7"; do_add(b, 2, 0); end
      6'b101111: begin tg = "R7"; do_sub(b, 1, 0); end
      6'b100110: begin tg = "R7"; do_sub(0, b, 0); end
      6'b100111: begin tg = "R7"; er = ~b & m; end
      6'b100010: begin tg = "R8"; er = ((b << 1) | cin) & m; eC = ((b >> (W - 1)) & 1) != 0; end
      6'b100011: begin tg = "R8"; er = (b << 1) & m; eC = ((b >> (W - 1)) & 1) != 0; end
      6'b110110: begin tg = "R8"; er = (b >> 1) | (cin << (W - 1)); eC = (b & 1) != 0; end
      6'b110111: begin tg = "R8"; er = b >> 1; eC = (b & 1) != 0; end
      default:   begin tg = "R10"; def = 0; ew = 0; end
    endcase
    if (instr[8] && def)
      ef = {((er >> 7) & 1) != 0, (er & 255) == 0, eC4, eC8, ((er >> (W - 1)) & 1) != 0, er == 0, eV, eC};
    else
      ef = flags_in;
  endtask

  function automatic logic [7:0] pick();
    case ($urandom % 8)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h80;
      3: return 8'h7F;
      4: return 8'h01;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] ef;
    instr = 16'hA3FF; a_lo = 8'hFF; b_lo = 8'hFF; flags_in = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1", {result, we_lo, we_hi, wb_idx, flags_out}, '0);
    rst_n = 1'b1;
    for (int h = 0; h < 256; h++) begin
      for (int k = 0; k < 24; k++) begin
        instr = {h[7:0], 4'($urandom), 4'($urandom)};
        a_lo = pick(); a_hi = pick(); b_lo = pick(); b_hi = pick();
        flags_in = 8'($urandom);
        model(ef);
        @(negedge clk);
        chk("R1", 32'(wb_idx), 32'(instr[3:0]));
        chk(ew ? "R2" : tg, {we_lo, we_hi}, {ew, ew && instr[9]});
        if (ew) begin
          chk(tg, 32'(result), 32'(er));
          if (!instr[9]) chk("R2", 32'(result[15:8]), 32'h0);
        end
        if (!def) chk("R10", 32'(flags_out), 32'(flags_in));
        else if (!instr[8]) chk("R3", 32'(flags_out), 32'(flags_in));
        else begin
          chk(tg, 32'(flags_out), 32'(ef));
          chk("R9", {flags_out[7:6], flags_out[3:2]}, {ef[7:6], ef[3:2]});
        end
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule